// File: doc/BRIEF.md
# Issue-Stage Structural Hazard Tracker

This block sits at the issue stage of a small in-order superscalar core. Each cycle it looks at up to three decoded instruction descriptors, each carrying a valid bit and a 4-bit operation class. It works out how many of them may leave for execution this cycle, taking them strictly in program order. Each issued instruction gets an execution unit: one of two simple integer units, the multiply pipe, the load/store unit, the floating-point unit or the branch unit. The block also reports the result latency of each issued instruction.

Operations that hold a unit for more than one cycle load a busy counter when they issue. The counter counts down each clock. Busy units block later operations of the same kind until they are free again. The affected operations are two- and three-cycle integer sequences, the integer divider and the FP divides. A stalled instruction, and every younger one in its group, stays un-issued. The caller presents those instructions again in a later cycle. A synchronous clear returns every counter to idle. Operand hazards and execution itself are outside this block.

Top module: `issue_resource_tracker`

## Requirements
- R1: Issue is in program order. The issued set is always slots 0..n-1, and it stops at the first slot that is invalid or whose resource is unavailable. `issue_count` equals the number of issued slots. A slot that does not issue reports grant code 0 and latency 0. Slot k uses bits k*4 of `in_class`, k*3 of `grant_unit` and k*7 of `result_lat`. Grant codes: 0 none, 1 simple unit 0, 2 simple unit 1, 3 multiply pipe, 4 load/store unit, 5 FP unit, 6 branch unit.
- R2: At most two non-branch operations and at most one branch-class operation issue per cycle, so at most three operations in total.
- R3: Simple integer class (code 0) uses simple unit 0 when it is free, otherwise simple unit 1, and has latency 1.
- R4: Condition-register move class (code 1) may use only simple unit 1 and has latency 1.
- R5: Two-cycle (code 2) and three-cycle (code 3) classes have latency 1. They keep their simple unit and one of the two non-branch issue slots for 2 or 3 consecutive cycles in total.
- R6: Multiply (code 4) uses the multiply pipe and has latency 4. Only one operation enters the pipe per cycle, but a new multiply may enter in every cycle.
- R7: Integer divide (code 5) enters the multiply pipe and has latency 14. A second divide can issue 14 cycles after the first and not earlier. Multiplies are not blocked by a running divide.
- R8: Branch class (code 6) uses the branch unit and no non-branch issue slot, and has latency 1.
- R9: Load/store class (code 7) has latency 3 and FP load (code 8) has latency 4. Both use the single load/store unit, once per cycle.
- R10: FP arithmetic (code 9) has latency 8 and double multiply (code 10) has latency 10. Both use the FP unit, once per cycle.
- R11: Single FP divide (code 11) holds the FP unit for 36 cycles with latency 36. Double FP divide (code 12) holds it for 66 cycles with latency 66. No FP operation issues in that time, and load/store operations are unaffected.
- R12: Reset and the synchronous clear return all busy counters to idle by the next cycle. Hold loads from operations issued in the clear cycle are dropped, although those operations still report as issued.
- R13: Class codes 13 to 15 never issue and stop the group at that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all busy state |
| in_valid | input | 3 | Valid bit per slot, bit 0 is oldest |
| in_class | input | 12 | Operation class per slot, 4 bits each |
| issue_mask | output | 3 | Slots issued this cycle |
| issue_count | output | 2 | Number of slots issued |
| grant_unit | output | 9 | Unit granted per slot, 3 bits each |
| result_lat | output | 21 | Result latency per slot, 7 bits each |

## Verification
The window assertions for divides and FP divides rely on `in_class` and `in_valid` being steady and two-state at the rising edge. They follow the block's occupancy only through the issued classes seen at the ports. The bench changes inputs only on the falling edge. It samples the combinational outputs mid-phase. Between scenarios it pulses `clr` or leaves idle cycles with all valid bits low, so that each scenario starts from idle units.

// File: rtl/irt_pkg.sv
package irt_pkg;

    parameter int NUM_SLOTS   = 3;
    parameter int CLS_W       = 4;
    parameter int UNIT_W      = 3;
    parameter int ISSUE_PAIRS = 2;
    parameter int NUM_SU      = 2;

    parameter int SIMPLE_LAT  = 1;
    parameter int MUL_LAT     = 4;
    parameter int DIV_CYCLES  = 14;
    parameter int LDST_LAT    = 3;
    parameter int FPLD_LAT    = 4;
    parameter int FP_LAT      = 8;
    parameter int DMUL_LAT    = 10;
    parameter int SDIV_CYCLES = 36;
    parameter int DDIV_CYCLES = 66;

    localparam int LAT_W     = $clog2(DDIV_CYCLES + 1);
    localparam int HOLD_W    = $clog2(DDIV_CYCLES);
    localparam int SU_HOLD_W = 2;
    localparam int DIV_W     = $clog2(DIV_CYCLES);
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1);

    localparam logic [CLS_W-1:0] CLS_ALU    = 4'd0;
    localparam logic [CLS_W-1:0] CLS_CRMOVE = 4'd1;
    localparam logic [CLS_W-1:0] CLS_TWO    = 4'd2;
    localparam logic [CLS_W-1:0] CLS_THREE  = 4'd3;
    localparam logic [CLS_W-1:0] CLS_MUL    = 4'd4;
    localparam logic [CLS_W-1:0] CLS_DIV    = 4'd5;
    localparam logic [CLS_W-1:0] CLS_BRANCH = 4'd6;
    localparam logic [CLS_W-1:0] CLS_LDST   = 4'd7;
    localparam logic [CLS_W-1:0] CLS_FPLOAD = 4'd8;
    localparam logic [CLS_W-1:0] CLS_FP     = 4'd9;
    localparam logic [CLS_W-1:0] CLS_DMUL   = 4'd10;
    localparam logic [CLS_W-1:0] CLS_SDIV   = 4'd11;
    localparam logic [CLS_W-1:0] CLS_DDIV   = 4'd12;

    typedef enum logic [UNIT_W-1:0] {
        U_NONE = 3'd0,
        U_SU0  = 3'd1,
        U_SU1  = 3'd2,
        U_MUL  = 3'd3,
        U_LSU  = 3'd4,
        U_FPU  = 3'd5,
        U_BRU  = 3'd6
    } unit_e;

    typedef enum logic [2:0] {
        K_SIMPLE,
        K_SU1,
        K_MUL,
        K_DIV,
        K_BRANCH,
        K_LSU,
        K_FP,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [LAT_W-1:0]  lat;
        logic [HOLD_W-1:0] hold;   // extra busy cycles after the issue cycle
    } op_info_t;

    function automatic op_info_t decode_class(input logic [CLS_W-1:0] cls);
        op_info_t r;
        r.kind = K_BAD;
        r.lat  = '0;
        r.hold = '0;
        case (cls)
            CLS_ALU:    begin r.kind = K_SIMPLE; r.lat = LAT_W'(SIMPLE_LAT); end
            CLS_CRMOVE: begin r.kind = K_SU1;    r.lat = LAT_W'(SIMPLE_LAT); end
            CLS_TWO:    begin r.kind = K_SIMPLE; r.lat = LAT_W'(SIMPLE_LAT); r.hold = HOLD_W'(1); end
            CLS_THREE:  begin r.kind = K_SIMPLE; r.lat = LAT_W'(SIMPLE_LAT); r.hold = HOLD_W'(2); end
            CLS_MUL:    begin r.kind = K_MUL;    r.lat = LAT_W'(MUL_LAT); end
            CLS_DIV:    begin r.kind = K_DIV;    r.lat = LAT_W'(DIV_CYCLES);
                              r.hold = HOLD_W'(DIV_CYCLES - 1); end
            CLS_BRANCH: begin r.kind = K_BRANCH; r.lat = LAT_W'(SIMPLE_LAT); end
            CLS_LDST:   begin r.kind = K_LSU;    r.lat = LAT_W'(LDST_LAT); end
            CLS_FPLOAD: begin r.kind = K_LSU;    r.lat = LAT_W'(FPLD_LAT); end
            CLS_FP:     begin r.kind = K_FP;     r.lat = LAT_W'(FP_LAT); end
            CLS_DMUL:   begin r.kind = K_FP;     r.lat = LAT_W'(DMUL_LAT); end
            CLS_SDIV:   begin r.kind = K_FP;     r.lat = LAT_W'(SDIV_CYCLES);
                              r.hold = HOLD_W'(SDIV_CYCLES - 1); end
            CLS_DDIV:   begin r.kind = K_FP;     r.lat = LAT_W'(DDIV_CYCLES);
                              r.hold = HOLD_W'(DDIV_CYCLES - 1); end
            default:    r.kind = K_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irt_busy_counter.sv
module irt_busy_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/irt_issue_arbiter.sv
module irt_issue_arbiter
    import irt_pkg::*;
(
    input  logic [NUM_SLOTS-1:0]  valid,
    input  op_info_t              info [NUM_SLOTS],
    input  logic [NUM_SU-1:0]     su_busy,
    input  logic                  div_busy,
    input  logic                  fp_busy,
    output logic [NUM_SLOTS-1:0]  issued,
    output unit_e                 grant [NUM_SLOTS],
    output logic [NUM_SU-1:0]     su_load,
    output logic [SU_HOLD_W-1:0]  su_load_val [NUM_SU],
    output logic                  div_load,
    output logic [DIV_W-1:0]      div_load_val,
    output logic                  fp_load,
    output logic [HOLD_W-1:0]     fp_load_val
);

    always_comb begin
        int                used;
        int                free_slots;
        int                pick;
        logic [NUM_SU-1:0] su_taken;
        logic              mu_taken;
        logic              lsu_taken;
        logic              fpu_taken;
        logic              br_taken;
        logic              stop;
        logic              ok;

        issued       = '0;
        su_load      = '0;
        div_load     = 1'b0;
        div_load_val = '0;
        fp_load      = 1'b0;
        fp_load_val  = '0;
        for (int s = 0; s < NUM_SU; s++) su_load_val[s] = '0;
        for (int k = 0; k < NUM_SLOTS; k++) grant[k] = U_NONE;

        // a unit still running a multi-cycle sequence also keeps its issue slot
        free_slots = ISSUE_PAIRS;
        for (int s = 0; s < NUM_SU; s++) if (su_busy[s]) free_slots = free_slots - 1;

        su_taken  = su_busy;
        mu_taken  = 1'b0;
        lsu_taken = 1'b0;
        fpu_taken = fp_busy;
        br_taken  = 1'b0;
        stop      = 1'b0;
        used      = 0;

        for (int k = 0; k < NUM_SLOTS; k++) begin
            ok   = 1'b0;
            pick = -1;
            if (!stop && valid[k]) begin
                if (info[k].kind == K_BRANCH) begin
                    if (!br_taken) begin
                        ok       = 1'b1;
                        br_taken = 1'b1;
                        grant[k] = U_BRU;
                    end
                end else if (used < free_slots) begin
                    case (info[k].kind)
                        K_SIMPLE: begin
                            for (int s = NUM_SU - 1; s >= 0; s--)
                                if (!su_taken[s]) pick = s;
                        end
                        K_SU1: begin
                            if (!su_taken[1]) pick = 1;
                        end
                        K_MUL: begin
                            if (!mu_taken) begin
                                ok       = 1'b1;
                                mu_taken = 1'b1;
                                grant[k] = U_MUL;
                            end
                        end
                        K_DIV: begin
                            if (!mu_taken && !div_busy) begin
                                ok           = 1'b1;
                                mu_taken     = 1'b1;
                                grant[k]     = U_MUL;
                                div_load     = 1'b1;
                                div_load_val = info[k].hold[DIV_W-1:0];
                            end
                        end
                        K_LSU: begin
                            if (!lsu_taken) begin
                                ok        = 1'b1;
                                lsu_taken = 1'b1;
                                grant[k]  = U_LSU;
                            end
                        end
                        K_FP: begin
                            if (!fpu_taken) begin
                                ok        = 1'b1;
                                fpu_taken = 1'b1;
                                grant[k]  = U_FPU;
                                if (info[k].hold != '0) begin
                                    fp_load     = 1'b1;
                                    fp_load_val = info[k].hold;
                                end
                            end
                        end
                        default: ok = 1'b0;
                    endcase
                    if (pick >= 0) begin
                        ok             = 1'b1;
                        su_taken[pick] = 1'b1;
                        grant[k]       = (pick == 0) ? U_SU0 : U_SU1;
                        if (info[k].hold != '0) begin
                            su_load[pick]     = 1'b1;
                            su_load_val[pick] = info[k].hold[SU_HOLD_W-1:0];
                        end
                    end
                    if (ok) used = used + 1;
                end
            end
            if (ok) issued[k] = 1'b1;
            else    stop      = 1'b1;
        end
    end

endmodule

// File: rtl/issue_resource_tracker.sv
module issue_resource_tracker
    import irt_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic [NUM_SLOTS-1:0]        in_valid,
    input  logic [NUM_SLOTS*CLS_W-1:0]  in_class,
    output logic [NUM_SLOTS-1:0]        issue_mask,
    output logic [CNT_W-1:0]            issue_count,
    output logic [NUM_SLOTS*UNIT_W-1:0] grant_unit,
    output logic [NUM_SLOTS*LAT_W-1:0]  result_lat
);

    op_info_t              info [NUM_SLOTS];
    unit_e                 grant [NUM_SLOTS];
    logic [NUM_SU-1:0]     su_busy;
    logic [NUM_SU-1:0]     su_load;
    logic [SU_HOLD_W-1:0]  su_load_val [NUM_SU];
    logic                  div_busy, div_load;
    logic [DIV_W-1:0]      div_load_val;
    logic                  fp_busy, fp_load;
    logic [HOLD_W-1:0]     fp_load_val;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign info[k] = decode_class(in_class[k*CLS_W +: CLS_W]);
        assign grant_unit[k*UNIT_W +: UNIT_W] = grant[k];
        assign result_lat[k*LAT_W +: LAT_W]   = issue_mask[k] ? info[k].lat : '0;
    end

    irt_issue_arbiter u_arb (
        .valid        (in_valid),
        .info         (info),
        .su_busy      (su_busy),
        .div_busy     (div_busy),
        .fp_busy      (fp_busy),
        .issued       (issue_mask),
        .grant        (grant),
        .su_load      (su_load),
        .su_load_val  (su_load_val),
        .div_load     (div_load),
        .div_load_val (div_load_val),
        .fp_load      (fp_load),
        .fp_load_val  (fp_load_val)
    );

    for (genvar s = 0; s < NUM_SU; s++) begin : g_su
        irt_busy_counter #(.W(SU_HOLD_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr),
            .load     (su_load[s]),
            .load_val (su_load_val[s]),
            .busy     (su_busy[s])
        );
    end

    irt_busy_counter #(.W(DIV_W)) u_div_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .load     (div_load),
        .load_val (div_load_val),
        .busy     (div_busy)
    );

    irt_busy_counter #(.W(HOLD_W)) u_fp_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .load     (fp_load),
        .load_val (fp_load_val),
        .busy     (fp_busy)
    );

    always_comb begin
        issue_count = '0;
        for (int k = 0; k < NUM_SLOTS; k++)
            issue_count = issue_count + CNT_W'(issue_mask[k]);
    end

endmodule

// File: rtl/irt_checker.sv
module irt_checker
    import irt_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        clr,
    input logic [NUM_SLOTS-1:0]        in_valid,
    input logic [NUM_SLOTS*CLS_W-1:0]  in_class,
    input logic [NUM_SLOTS-1:0]        issue_mask,
    input logic [CNT_W-1:0]            issue_count,
    input logic [NUM_SLOTS*UNIT_W-1:0] grant_unit,
    input logic [NUM_SLOTS*LAT_W-1:0]  result_lat
);

    logic [NUM_SLOTS-1:0] mask_inc;
    int                   nb_cnt, br_cnt;
    logic                 div_now, fp_now, fp_long_now;
    logic [HOLD_W-1:0]    fp_hold;
    logic [DIV_W-1:0]     div_win;
    logic [HOLD_W-1:0]    fp_win;

    assign mask_inc = issue_mask + 1'b1;

    always_comb begin
        logic [CLS_W-1:0] c;
        nb_cnt      = 0;
        br_cnt      = 0;
        div_now     = 1'b0;
        fp_now      = 1'b0;
        fp_long_now = 1'b0;
        fp_hold     = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            c = in_class[k*CLS_W +: CLS_W];
            if (issue_mask[k]) begin
                if (c == CLS_BRANCH) br_cnt = br_cnt + 1;
                else                 nb_cnt = nb_cnt + 1;
                if (c == CLS_DIV) div_now = 1'b1;
                if (c == CLS_FP || c == CLS_DMUL || c == CLS_SDIV || c == CLS_DDIV)
                    fp_now = 1'b1;
                if (c == CLS_SDIV) begin fp_long_now = 1'b1; fp_hold = HOLD_W'(SDIV_CYCLES - 1); end
                if (c == CLS_DDIV) begin fp_long_now = 1'b1; fp_hold = HOLD_W'(DDIV_CYCLES - 1); end
            end
        end
    end

    // independent occupancy windows seen from the ports
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_win <= '0;
            fp_win  <= '0;
        end else begin
            if (div_now)              div_win <= DIV_W'(DIV_CYCLES - 1);
            else if (div_win != '0)   div_win <= div_win - 1'b1;
            if (fp_long_now)          fp_win  <= fp_hold;
            else if (fp_win != '0)    fp_win  <= fp_win - 1'b1;
        end
    end

    a_r1_in_order_prefix: assert property (@(posedge clk) disable iff (rst)
        (mask_inc & issue_mask) == '0);

    a_r1_count_matches: assert property (@(posedge clk) disable iff (rst)
        int'(issue_count) == $countones(issue_mask));

    a_r2_issue_limits: assert property (@(posedge clk) disable iff (rst)
        (nb_cnt <= ISSUE_PAIRS) && (br_cnt <= 1));

    a_r7_div_window: assert property (@(posedge clk) disable iff (rst)
        (div_win != '0) |-> !div_now);

    a_r11_fp_window: assert property (@(posedge clk) disable iff (rst)
        (fp_win != '0) |-> !fp_now);

    a_r12_clear_frees_fpu: assert property (@(posedge clk) disable iff (rst)
        ($past(clr) && in_valid[0] && in_class[CLS_W-1:0] == CLS_FP) |-> issue_mask[0]);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        a_r4_crmove_unit: assert property (@(posedge clk) disable iff (rst)
            (issue_mask[k] && in_class[k*CLS_W +: CLS_W] == CLS_CRMOVE)
            |-> grant_unit[k*UNIT_W +: UNIT_W] == U_SU1);

        a_r13_bad_class_blocked: assert property (@(posedge clk) disable iff (rst)
            (in_class[k*CLS_W +: CLS_W] > CLS_DDIV) |-> !issue_mask[k]);

        a_r1_idle_slot_quiet: assert property (@(posedge clk) disable iff (rst)
            !issue_mask[k] |-> (grant_unit[k*UNIT_W +: UNIT_W] == '0
                                && result_lat[k*LAT_W +: LAT_W] == '0));
    end

endmodule

bind issue_resource_tracker irt_checker u_irt_checker (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .issue_mask  (issue_mask),
    .issue_count (issue_count),
    .grant_unit  (grant_unit),
    .result_lat  (result_lat)
);

// File: tb/issue_resource_tracker_test.sv
module issue_resource_tracker_test;

    localparam logic [3:0] ALU = 4'd0, CRM = 4'd1, TWO = 4'd2, THR = 4'd3,
                           MUL = 4'd4, DIV = 4'd5, BR = 4'd6, LDS = 4'd7,
                           FPL = 4'd8, FPA = 4'd9, DML = 4'd10, SDV = 4'd11,
                           DDV = 4'd12, BAD = 4'd14;
    localparam logic [2:0] GN = 3'd0, G0 = 3'd1, G1 = 3'd2, GM = 3'd3,
                           GL = 3'd4, GF = 3'd5, GB = 3'd6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic [2:0]  in_valid = '0;
    logic [11:0] in_class = '0;
    logic [2:0]  issue_mask;
    logic [1:0]  issue_count;
    logic [8:0]  grant_unit;
    logic [20:0] result_lat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    issue_resource_tracker uut (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .in_valid    (in_valid),
        .in_class    (in_class),
        .issue_mask  (issue_mask),
        .issue_count (issue_count),
        .grant_unit  (grant_unit),
        .result_lat  (result_lat)
    );

    // One cycle: drive at the falling edge, check mid-phase, move to next falling edge.
    task automatic cyc(input string req, input logic [2:0] v,
                       input logic [3:0] c0, input logic [3:0] c1, input logic [3:0] c2,
                       input logic [2:0] em,
                       input logic [2:0] g0, input logic [2:0] g1, input logic [2:0] g2,
                       input int l0, input int l1, input int l2);
        logic [8:0]  eg;
        logic [20:0] el;
        logic [1:0]  ec;
        in_valid = v;
        in_class = {c2, c1, c0};
        eg = {g2, g1, g0};
        el = {7'(l2), 7'(l1), 7'(l0)};
        ec = 2'(em[0]) + 2'(em[1]) + 2'(em[2]);
        #5;
        n_cmp++;
        if (issue_mask !== em || issue_count !== ec || grant_unit !== eg || result_lat !== el) begin
            n_bad++;
            $display("FAIL %s: mask/count/grant/lat actual %b/%0d/%h/%h expected %b/%0d/%h/%h",
                     req, issue_mask, issue_count, grant_unit, result_lat, em, ec, eg, el);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        idle(1);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        // R12: after reset every unit is idle; nothing issues with no valid slot
        cyc("R12 reset idle", 3'b000, ALU, ALU, ALU, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R12 fpu free after reset", 3'b001, FPA, ALU, ALU, 3'b001, GF, GN, GN, 8, 0, 0);
    endtask

    task automatic t_simple();
        cyc("R3 R2 two simple of three", 3'b111, ALU, ALU, ALU, 3'b011, G0, G1, GN, 1, 1, 0);
        cyc("R8 branch beside pair", 3'b111, ALU, ALU, BR, 3'b111, G0, G1, GB, 1, 1, 1);
        cyc("R2 second branch stalls", 3'b111, BR, BR, ALU, 3'b001, GB, GN, GN, 1, 0, 0);
        cyc("R4 crmove only unit 1", 3'b011, CRM, CRM, ALU, 3'b001, G1, GN, GN, 1, 0, 0);
        cyc("R4 crmove then simple", 3'b011, CRM, ALU, ALU, 3'b011, G1, G0, GN, 1, 1, 0);
        cyc("R1 invalid slot 0 stops", 3'b110, ALU, ALU, BR, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R2 mixed non-branch limit", 3'b111, FPA, LDS, ALU, 3'b011, GF, GL, GN, 8, 3, 0);
    endtask

    task automatic t_multi();
        cyc("R5 two-cycle issues", 3'b001, TWO, ALU, ALU, 3'b001, G0, GN, GN, 1, 0, 0);
        cyc("R5 two-cycle holds unit 0", 3'b011, ALU, ALU, ALU, 3'b001, G1, GN, GN, 1, 0, 0);
        cyc("R5 two-cycle released", 3'b011, ALU, ALU, ALU, 3'b011, G0, G1, GN, 1, 1, 0);
        cyc("R5 three-cycle issues", 3'b001, THR, ALU, ALU, 3'b001, G0, GN, GN, 1, 0, 0);
        cyc("R5 three-cycle hold 1", 3'b011, ALU, ALU, ALU, 3'b001, G1, GN, GN, 1, 0, 0);
        cyc("R5 three-cycle hold 2", 3'b011, ALU, ALU, ALU, 3'b001, G1, GN, GN, 1, 0, 0);
        cyc("R5 three-cycle released", 3'b011, ALU, ALU, ALU, 3'b011, G0, G1, GN, 1, 1, 0);
    endtask

    task automatic t_mul_div();
        cyc("R6 one multiply per cycle", 3'b011, MUL, MUL, ALU, 3'b001, GM, GN, GN, 4, 0, 0);
        cyc("R6 multiply back to back", 3'b001, MUL, ALU, ALU, 3'b001, GM, GN, GN, 4, 0, 0);
        cyc("R7 divide issues", 3'b001, DIV, ALU, ALU, 3'b001, GM, GN, GN, 14, 0, 0);
        cyc("R7 second divide blocked", 3'b001, DIV, ALU, ALU, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R7 multiply during divide", 3'b001, MUL, ALU, ALU, 3'b001, GM, GN, GN, 4, 0, 0);
        idle(10);
        cyc("R7 divide blocked at 13", 3'b001, DIV, ALU, ALU, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R7 divide free at 14", 3'b001, DIV, ALU, ALU, 3'b001, GM, GN, GN, 14, 0, 0);
        pulse_clr();
        cyc("R12 divide free after clear", 3'b001, DIV, ALU, ALU, 3'b001, GM, GN, GN, 14, 0, 0);
        pulse_clr();
        cyc("R7 divide and multiply share entry", 3'b011, DIV, MUL, ALU, 3'b001, GM, GN, GN, 14, 0, 0);
        pulse_clr();
    endtask

    task automatic t_lsu();
        cyc("R9 single load/store unit", 3'b111, LDS, LDS, FPL, 3'b001, GL, GN, GN, 3, 0, 0);
        cyc("R9 fp load latency", 3'b011, FPL, ALU, ALU, 3'b011, GL, G0, GN, 4, 1, 0);
    endtask

    task automatic t_fp();
        cyc("R10 single fp unit", 3'b011, FPA, DML, ALU, 3'b001, GF, GN, GN, 8, 0, 0);
        cyc("R10 double multiply latency", 3'b001, DML, ALU, ALU, 3'b001, GF, GN, GN, 10, 0, 0);
        cyc("R11 single divide issues", 3'b001, SDV, ALU, ALU, 3'b001, GF, GN, GN, 36, 0, 0);
        cyc("R11 lsu free, fp blocked", 3'b011, LDS, FPA, ALU, 3'b001, GL, GN, GN, 3, 0, 0);
        idle(33);
        cyc("R11 fp blocked at 35", 3'b001, FPA, ALU, ALU, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R11 fp free at 36", 3'b001, FPA, ALU, ALU, 3'b001, GF, GN, GN, 8, 0, 0);
        cyc("R11 double divide issues", 3'b001, DDV, ALU, ALU, 3'b001, GF, GN, GN, 66, 0, 0);
        idle(64);
        cyc("R11 fp blocked at 65", 3'b001, DML, ALU, ALU, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R11 fp free at 66", 3'b001, DML, ALU, ALU, 3'b001, GF, GN, GN, 10, 0, 0);
    endtask

    task automatic t_clear();
        clr = 1'b1;
        cyc("R12 issue in clear cycle", 3'b001, DDV, ALU, ALU, 3'b001, GF, GN, GN, 66, 0, 0);
        clr = 1'b0;
        cyc("R12 clear drops hold load", 3'b001, FPA, ALU, ALU, 3'b001, GF, GN, GN, 8, 0, 0);
    endtask

    task automatic t_bad();
        cyc("R13 unused code stalls", 3'b011, BAD, ALU, ALU, 3'b000, GN, GN, GN, 0, 0, 0);
        cyc("R13 unused code ends group", 3'b111, ALU, BAD, BR, 3'b001, G0, GN, GN, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_simple();
        t_multi();
        t_mul_div();
        t_lsu();
        t_fp();
        t_clear();
        t_bad();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule